// File: doc/BRIEF.md
# Parallel ADC Conversion and Readout Sequencer

This block is the host-side controller for a 12-bit successive-approximation converter whose result appears on a parallel bus that floats whenever it is not addressed. When a start request is accepted, the sequencer drives the converter's active-low read/convert strobe and its active-low chip select. It waits for the converter's busy flag to drop and then rise again. It then reads the straight-binary result, either as one 12-bit word or as two bytes taken through an 8-bit lane while a byte-select line is toggled. The result is presented with a one-cycle valid pulse.

All timing is counted in system clock cycles through parameters: the strobe setup and width, the bus access time after chip select or a byte-select change, the minimum spacing between conversions, and two watchdog limits on the busy flag. Busy is passed through a two-flop synchronizer. The states are ST_IDLE, ST_STROBE, ST_WAIT_FALL, ST_WAIT_RISE, ST_READ_HI, ST_READ_LO, ST_DONE and ST_SPACING. The transitions are:
- ST_IDLE to ST_STROBE when start is accepted.
- ST_STROBE to ST_WAIT_FALL when the strobe timer ends.
- ST_WAIT_FALL to ST_WAIT_RISE when busy is low, or to ST_IDLE with the error flag on timeout.
- ST_WAIT_RISE to ST_READ_HI on a busy rising edge, or to ST_IDLE with the error flag on timeout.
- ST_READ_HI to ST_DONE in word mode, or to ST_READ_LO in byte mode.
- ST_READ_LO to ST_DONE.
- ST_DONE to ST_SPACING.
- ST_SPACING to ST_IDLE once the spacing interval has elapsed.

Top module: `adc_rdout_seq`

## Requirements
- R1: In reset and directly after it, conv_n and cs_n are 1, byte_sel is 0, and result_valid and timeout_err are 0.
- R2: After an accepted start, conv_n is low with cs_n high for exactly SETUP_CYC cycles. Then conv_n and cs_n are both low for exactly PULSE_CYC cycles. After that, both return high.
- R3: The first read cycle (cs_n low, conv_n high) starts on the third clock edge after busy_in goes high.
- R4: Each read window holds cs_n low with conv_n high for exactly ACCESS_CYC cycles. bus_in is captured only on the last cycle of such a window.
- R5: With word_mode=1 there is a single read window with byte_sel=0, and result equals bus_in[11:0].
- R6: With word_mode=0 there are two windows. In the first, byte_sel=0 and bus_in[11:4] carries result[11:4]. In the second, byte_sel=1, bus_in[11:8] carries result[3:0] and bus_in[7:4] reads zero. bus_in[3:0] has no effect in this mode.
- R7: result_valid is high for exactly one cycle per completed conversion, and result is valid in that same cycle.
- R8: Straight-binary codes pass through unchanged: 0x000 (zero scale), 0x800 (midscale) and 0xFFF (full scale).
- R9: Two strobe falling edges are never closer than SPACE_CYC cycles. When start is held high, the next strobe follows after SPACE_CYC+1 cycles.
- R10: A start request that arrives while a sequence is in progress launches no extra strobe.
- R11: If busy_in is not seen low within TOUT_FALL cycles after the strobe, timeout_err is set, the block returns to idle with conv_n and cs_n high, and no read or valid pulse occurs.
- R12: If no busy_in rising edge arrives within TOUT_RISE cycles, timeout_err is set and the block returns to idle with no read or valid pulse.
- R13: timeout_err stays set until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, accepted only when idle and spacing has elapsed |
| word_mode | input | 1 | 1: one 12-bit read; 0: two reads through the 8-bit lane |
| busy_in | input | 1 | Converter busy flag, asynchronous, low while converting |
| bus_in | input | 12 | Converter parallel data bus |
| conv_n | output | 1 | Read/convert strobe, low starts a conversion |
| cs_n | output | 1 | Converter chip select, active low |
| byte_sel | output | 1 | Byte select for the 8-bit lane |
| result | output | 12 | Reassembled straight-binary result |
| result_valid | output | 1 | One-cycle pulse marking a new result |
| timeout_err | output | 1 | Busy watchdog fired; cleared by the next accepted start |

## Verification
The strobe appears on the edge that accepts start. It is checked as SETUP_CYC cycles of conv_n low with cs_n high, followed by PULSE_CYC cycles with both low. Because of the two synchronizer flops and one state edge, the first read cycle is due three edges after busy_in rises. Each read window lasts ACCESS_CYC cycles, and result_valid comes one edge after the last capture. The bench samples every output on the falling clock edge and stamps events with a rising-edge cycle counter, so these distances are measured as exact cycle differences. The timeout flag is checked after the full watchdog interval has safely passed.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    localparam int RES_W  = 12;
    localparam int LANE_W = 8;
    localparam int TAIL_W = RES_W - LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE,
        ST_WAIT_FALL,
        ST_WAIT_RISE,
        ST_READ_HI,
        ST_READ_LO,
        ST_DONE,
        ST_SPACING
    } seq_state_t;
endpackage

// File: rtl/adcseq_busy_sync.sv
module adcseq_busy_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_async,
    output logic busy_lvl,
    output logic busy_rise
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= busy_async;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign busy_lvl  = s2;
    assign busy_rise = s2 & ~s3;
endmodule

// File: rtl/adcseq_gap.sv
module adcseq_gap #(
    parameter int SPACE_CYC = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic gap_done
);
    localparam int GW = $clog2(SPACE_CYC + 1);
    logic [GW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= GW'(SPACE_CYC - 1);
        else if (cnt != '0)
            cnt <= cnt - GW'(1);
    end

    assign gap_done = (cnt == '0);
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int SETUP_CYC  = 3,
    parameter int PULSE_CYC  = 10,
    parameter int ACCESS_CYC = 21,
    parameter int TOUT_FALL  = 16,
    parameter int TOUT_RISE  = 2500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             word_mode,
    input  logic             busy_lvl,
    input  logic             busy_rise,
    input  logic             gap_done,
    input  logic [RES_W-1:0] bus_in,
    output logic             gap_load,
    output logic             conv_n,
    output logic             cs_n,
    output logic             byte_sel,
    output logic [RES_W-1:0] result,
    output logic             result_valid,
    output logic             timeout_err
);
    localparam int T_A   = (SETUP_CYC + PULSE_CYC > ACCESS_CYC) ? SETUP_CYC + PULSE_CYC : ACCESS_CYC;
    localparam int T_B   = (TOUT_FALL > TOUT_RISE) ? TOUT_FALL : TOUT_RISE;
    localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
    localparam int TW    = $clog2(T_MAX + 1);
    localparam logic [TW-1:0] LD_STROBE = TW'(SETUP_CYC + PULSE_CYC - 1);
    localparam logic [TW-1:0] LD_FALL   = TW'(TOUT_FALL - 1);
    localparam logic [TW-1:0] LD_RISE   = TW'(TOUT_RISE - 1);
    localparam logic [TW-1:0] LD_ACC    = TW'(ACCESS_CYC - 1);

    seq_state_t         state, state_d;
    logic [TW-1:0]      tmr, tmr_d;
    logic               tmr_z;
    logic               mode_q;
    logic [LANE_W-1:0]  hi_q;
    logic [RES_W-1:0]   res_q;
    logic               err_q;
    logic               to_hit;

    assign tmr_z = (tmr == '0);

    // next-state and timer
    always_comb begin
        state_d = state;
        tmr_d   = tmr_z ? tmr : tmr - TW'(1);
        to_hit  = 1'b0;
        unique case (state)
            ST_IDLE:
                if (start && gap_done) begin
                    state_d = ST_STROBE;
                    tmr_d   = LD_STROBE;
                end
            ST_STROBE:
                if (tmr_z) begin
                    state_d = ST_WAIT_FALL;
                    tmr_d   = LD_FALL;
                end
            ST_WAIT_FALL:
                if (!busy_lvl) begin
                    state_d = ST_WAIT_RISE;
                    tmr_d   = LD_RISE;
                end else if (tmr_z) begin
                    state_d = ST_IDLE;
                    to_hit  = 1'b1;
                end
            ST_WAIT_RISE:
                if (busy_rise) begin
                    state_d = ST_READ_HI;
                    tmr_d   = LD_ACC;
                end else if (tmr_z) begin
                    state_d = ST_IDLE;
                    to_hit  = 1'b1;
                end
            ST_READ_HI:
                if (tmr_z) begin
                    state_d = mode_q ? ST_DONE : ST_READ_LO;
                    tmr_d   = LD_ACC;
                end
            ST_READ_LO:
                if (tmr_z) state_d = ST_DONE;
            ST_DONE:
                state_d = ST_SPACING;
            ST_SPACING:
                if (gap_done) state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // state register and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tmr    <= '0;
            mode_q <= 1'b1;
            hi_q   <= '0;
            res_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            state <= state_d;
            tmr   <= tmr_d;
            if (gap_load) begin
                mode_q <= word_mode;
                err_q  <= 1'b0;
            end else if (to_hit) begin
                err_q  <= 1'b1;
            end
            if (state == ST_READ_HI && tmr_z) begin
                if (mode_q) res_q <= bus_in;
                else        hi_q  <= bus_in[RES_W-1 -: LANE_W];
            end
            if (state == ST_READ_LO && tmr_z)
                res_q <= {hi_q, bus_in[RES_W-1 -: TAIL_W]};
        end
    end

    // outputs
    always_comb begin
        gap_load     = (state == ST_IDLE) && start && gap_done;
        conv_n       = (state != ST_STROBE);
        cs_n         = !(((state == ST_STROBE) && (tmr < TW'(PULSE_CYC))) ||
                         (state == ST_READ_HI) || (state == ST_READ_LO));
        byte_sel     = (state == ST_READ_LO);
        result_valid = (state == ST_DONE);
        result       = res_q;
        timeout_err  = err_q;
    end

    // checking logic: run length of the joint low strobe
    logic [TW-1:0] pw_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pw_cnt <= '0;
        else if (!conv_n && !cs_n)  pw_cnt <= (pw_cnt == '1) ? pw_cnt : pw_cnt + TW'(1);
        else                        pw_cnt <= '0;
    end

    assert_strobe_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_n && !cs_n) |-> (pw_cnt < TW'(PULSE_CYC)));

    assert_cs_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && !conv_n) |-> $past(!conv_n));

    assert_read_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ_HI && $past(state) == ST_WAIT_RISE) |-> busy_lvl);

    assert_byte_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_sel) |-> (!cs_n && $past(!cs_n) && conv_n));

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    assert_err_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (state == ST_IDLE && conv_n && cs_n));
endmodule

// File: rtl/adc_rdout_seq.sv
module adc_rdout_seq
    import adcseq_pkg::*;
#(
    parameter int SETUP_CYC  = 3,
    parameter int PULSE_CYC  = 10,
    parameter int ACCESS_CYC = 21,
    parameter int SPACE_CYC  = 2500,
    parameter int TOUT_FALL  = 16,
    parameter int TOUT_RISE  = 2500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             word_mode,
    input  logic             busy_in,
    input  logic [RES_W-1:0] bus_in,
    output logic             conv_n,
    output logic             cs_n,
    output logic             byte_sel,
    output logic [RES_W-1:0] result,
    output logic             result_valid,
    output logic             timeout_err
);
    logic busy_lvl, busy_rise, gap_done, gap_load;

    adcseq_busy_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_async (busy_in),
        .busy_lvl   (busy_lvl),
        .busy_rise  (busy_rise)
    );

    adcseq_gap #(.SPACE_CYC(SPACE_CYC)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .gap_done (gap_done)
    );

    adcseq_fsm #(
        .SETUP_CYC  (SETUP_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .TOUT_FALL  (TOUT_FALL),
        .TOUT_RISE  (TOUT_RISE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .word_mode    (word_mode),
        .busy_lvl     (busy_lvl),
        .busy_rise    (busy_rise),
        .gap_done     (gap_done),
        .bus_in       (bus_in),
        .gap_load     (gap_load),
        .conv_n       (conv_n),
        .cs_n         (cs_n),
        .byte_sel     (byte_sel),
        .result       (result),
        .result_valid (result_valid),
        .timeout_err  (timeout_err)
    );

    // checking logic: cycles since the previous strobe fall
    localparam int SW = $clog2(SPACE_CYC + 2);
    logic          conv_prev, fall_seen;
    logic [SW-1:0] since_fall;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_prev  <= 1'b1;
            fall_seen  <= 1'b0;
            since_fall <= '0;
        end else begin
            conv_prev <= conv_n;
            if (!conv_n && conv_prev) begin
                fall_seen  <= 1'b1;
                since_fall <= SW'(1);
            end else if (since_fall != SW'(SPACE_CYC + 1)) begin
                since_fall <= since_fall + SW'(1);
            end
        end
    end

    assert_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_n && conv_prev && fall_seen) |-> (since_fall >= SW'(SPACE_CYC)));
endmodule

// File: tb/test_adc_rdout_seq.sv
`timescale 1ns/1ps
module test_adc_rdout_seq;
    localparam int SETUP  = 3;
    localparam int PULSE  = 10;
    localparam int ACC    = 21;
    localparam int SPACE  = 300;
    localparam int TFALL  = 16;
    localparam int TRISE  = 400;
    localparam int CONV   = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic word_mode = 1'b1;
    logic busy = 1'b1;
    logic conv_n, cs_n, byte_sel, result_valid, timeout_err;
    logic [11:0] result;
    wire  [11:0] bus_w;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    // converter stub state
    logic [11:0] dreg = 12'h000;
    logic [11:0] code_next = 12'h000;
    logic        garble = 1'b0;
    logic        st_nofall = 1'b0;
    logic        st_norise = 1'b0;
    int          cyc = 0;
    int          rise_cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    assign bus_w = (conv_n && !cs_n)
        ? (byte_sel ? {dreg[3:0], 4'h0, (garble ? 4'hA : dreg[11:8])}
                    : {dreg[11:4], (garble ? ~dreg[3:0] : dreg[3:0])})
        : 12'hzzz;

    initial begin
        forever begin
            @(negedge clk);
            if (!conv_n && !cs_n) begin
                if (!st_nofall) begin
                    busy = 1'b0;
                    if (st_norise) begin
                        wait (!st_norise);
                        @(negedge clk);
                        busy = 1'b1;
                    end else begin
                        repeat (CONV) @(negedge clk);
                        dreg     = code_next;
                        busy     = 1'b1;
                        rise_cyc = cyc;
                    end
                end
                while (!conv_n) @(negedge clk);
            end
        end
    end

    adc_rdout_seq #(
        .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .ACCESS_CYC(ACC),
        .SPACE_CYC(SPACE), .TOUT_FALL(TFALL), .TOUT_RISE(TRISE)
    ) i_adc_rdout_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
        .busy_in(busy), .bus_in(bus_w), .conv_n(conv_n), .cs_n(cs_n),
        .byte_sel(byte_sel), .result(result), .result_valid(result_valid),
        .timeout_err(timeout_err)
    );

    // monitor, sampled on the falling edge
    int clr_gen = 0, clr_seen = 0;
    int setup_len, pulse_len, rd0_len, rd1_len, valid_cnt, fall_cnt;
    int fall0_cyc, fall1_cyc, rd_first_cyc, falls_at_valid;
    logic [11:0] last_res;
    logic conv_prev = 1'b1;

    always @(negedge clk) begin
        if (clr_gen != clr_seen) begin
            clr_seen = clr_gen;
            setup_len = 0; pulse_len = 0; rd0_len = 0; rd1_len = 0;
            valid_cnt = 0; fall_cnt = 0; fall0_cyc = 0; fall1_cyc = 0;
            rd_first_cyc = -1; falls_at_valid = 0; last_res = 12'h000;
        end else begin
            if (!conv_n && cs_n)  setup_len++;
            if (!conv_n && !cs_n) pulse_len++;
            if (conv_n && !cs_n) begin
                if (rd_first_cyc < 0) rd_first_cyc = cyc;
                if (byte_sel) rd1_len++; else rd0_len++;
            end
            if (!conv_n && conv_prev) begin
                if (fall_cnt == 0) fall0_cyc = cyc;
                if (fall_cnt == 1) fall1_cyc = cyc;
                fall_cnt++;
            end
            if (result_valid) begin
                if (valid_cnt == 0) falls_at_valid = fall_cnt;
                valid_cnt++;
                last_res = result;
            end
        end
        conv_prev = conv_n;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        clr_gen++;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_valid(input int n, input int want);
        for (int i = 0; i < n && valid_cnt < want; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(conv_n == 1'b1, "R1 conv_n in reset", conv_n, 1);
        check(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
        check(byte_sel == 1'b0, "R1 byte_sel in reset", byte_sel, 0);
        check(result_valid == 1'b0, "R1 valid in reset", result_valid, 0);
        check(timeout_err == 1'b0, "R1 error in reset", timeout_err, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(conv_n && cs_n && !result_valid, "R1 idle after reset", conv_n, 1);
    endtask

    task automatic t_full(input logic [11:0] code);
        clear_mon();
        word_mode = 1'b1; garble = 1'b0; code_next = code;
        pulse_start();
        wait_valid(1000, 1);
        check(setup_len == SETUP, "R2 setup length", setup_len, SETUP);
        check(pulse_len == PULSE, "R2 strobe width", pulse_len, PULSE);
        check(rd_first_cyc - rise_cyc == 3, "R3 read latency", rd_first_cyc - rise_cyc, 3);
        check(rd0_len == ACC, "R4 read window", rd0_len, ACC);
        check(rd1_len == 0, "R5 no second window", rd1_len, 0);
        check(last_res == code, "R5 R8 full word result", last_res, code);
        check(valid_cnt == 1, "R7 single valid", valid_cnt, 1);
        repeat (SPACE + 20) @(negedge clk);
    endtask

    task automatic t_byte(input logic [11:0] code);
        clear_mon();
        word_mode = 1'b0; garble = 1'b1; code_next = code;
        pulse_start();
        repeat (60) @(negedge clk);
        pulse_start();   // arrives while waiting for busy
        wait_valid(1000, 1);
        check(rd0_len == ACC, "R6 upper byte window", rd0_len, ACC);
        check(rd1_len == ACC, "R6 lower byte window", rd1_len, ACC);
        check(last_res == code, "R6 byte result", last_res, code);
        check(valid_cnt == 1, "R7 single valid byte mode", valid_cnt, 1);
        check(fall_cnt == 1, "R10 mid-sequence start ignored", fall_cnt, 1);
        garble = 1'b0;
        repeat (SPACE + 20) @(negedge clk);
    endtask

    task automatic t_spacing();
        clear_mon();
        word_mode = 1'b1; code_next = 12'h5A3;
        @(negedge clk) start = 1'b1;
        for (int i = 0; i < 2000 && fall_cnt < 2; i++) @(negedge clk);
        start = 1'b0;
        check(falls_at_valid == 1, "R10 held start gives one strobe", falls_at_valid, 1);
        check(fall1_cyc - fall0_cyc >= SPACE && fall1_cyc - fall0_cyc <= SPACE + 2,
              "R9 strobe spacing", fall1_cyc - fall0_cyc, SPACE + 1);
        wait_valid(1000, 2);
        check(last_res == 12'h5A3, "R9 second result", last_res, 12'h5A3);
        repeat (SPACE + 20) @(negedge clk);
    endtask

    task automatic t_to_fall();
        clear_mon();
        st_nofall = 1'b1;
        pulse_start();
        repeat (SETUP + PULSE + TFALL + 20) @(negedge clk);
        check(timeout_err == 1'b1, "R11 fall timeout flag", timeout_err, 1);
        check(conv_n && cs_n, "R11 idle outputs", cs_n, 1);
        check(rd0_len + rd1_len == 0, "R11 no read", rd0_len + rd1_len, 0);
        check(valid_cnt == 0, "R11 no valid", valid_cnt, 0);
        st_nofall = 1'b0;
        repeat (SPACE + 20) @(negedge clk);
        check(timeout_err == 1'b1, "R13 flag held", timeout_err, 1);
    endtask

    task automatic t_err_clear();
        clear_mon();
        word_mode = 1'b1; code_next = 12'h123;
        pulse_start();
        check(timeout_err == 1'b0, "R13 flag cleared on start", timeout_err, 0);
        wait_valid(1000, 1);
        check(last_res == 12'h123, "R13 conversion after error", last_res, 12'h123);
        repeat (SPACE + 20) @(negedge clk);
    endtask

    task automatic t_to_rise();
        clear_mon();
        st_norise = 1'b1;
        pulse_start();
        repeat (SETUP + PULSE + TRISE + 40) @(negedge clk);
        check(timeout_err == 1'b1, "R12 rise timeout flag", timeout_err, 1);
        check(conv_n && cs_n, "R12 idle outputs", cs_n, 1);
        check(rd0_len + rd1_len == 0, "R12 no read", rd0_len + rd1_len, 0);
        check(valid_cnt == 0, "R12 no valid", valid_cnt, 0);
        st_norise = 1'b0;
        repeat (SPACE + 20) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_full(12'h800);
        t_full(12'hFFF);
        t_full(12'h000);
        t_byte(12'hA5C);
        t_byte(12'h3F1);
        t_spacing();
        t_to_fall();
        t_err_clear();
        t_to_rise();
        t_full(12'h7FF);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule